// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block sits between a UART's bit-level receiver and the host. Each completed character comes in on a valid/ready stream and is stored in a 16-entry first-in first-out queue. The host drains the queue through a second valid/ready stream: the oldest character is always presented, and a handshake removes it. A fill-level comparator raises a trigger flag once the queue holds a selectable number of characters. Characters can keep arriving after the trigger is reached, until the queue is full.

A character timer keeps a few characters below the trigger from waiting forever. It counts bit-time ticks while the queue holds data. Every stop-bit-centre strobe, every host read and every arriving character clears it. When it reaches four times the word length plus twelve, it raises a timeout flag. The flag stays set until the host reads or a new character arrives.

The input side has back-pressure only in name. `in_ready` tells the upstream receiver whether there is room. The receiver cannot stall the line, so a character offered while `in_ready` is low is discarded and a sticky overrun flag is set. On the output side `out_valid` stays high for as long as data is held, and `out_ready` may be asserted at any time. With queueing disabled, the block acts as a single holding register.

Top module: `rx_char_queue`

## Requirements
- R1: Characters leave in the order they arrived. `out_data` shows the oldest stored character whenever `out_valid` is high, and a cycle with `out_valid` and `out_ready` both high removes it.
- R2: Capacity is 16 characters when `fifo_en` is 1 and 1 character when it is 0. `in_ready` is high exactly when the stored count is below capacity. Any change of `fifo_en` between two clock edges empties the queue, and `in_ready` is low during that cycle.
- R3: A character offered with `in_valid` high while `in_ready` is low is dropped and sets `overrun` from the next cycle on. `overrun` stays set until a cycle with `status_rd` high in which no new drop occurs.
- R4: `out_valid` is high exactly when at least one character is stored. It falls in the cycle after the last character is read.
- R5: `trig_hit` is high when the stored count is at least the trigger level. `trig_sel` 00, 01, 10 and 11 select levels 1, 4, 8 and 14. With `fifo_en` at 0 the level is 1. Storing continues past the level.
- R6: The timeout length in bit ticks is 4*W+12, where `wlen_sel` 00, 01, 10 and 11 give W = 5, 6, 7 and 8 (32, 36, 40 and 44 ticks). `tmo_flag` rises in the cycle after the tick that completes the length, counting from the last clear.
- R7: The tick count restarts from zero on a cycle with `stop_mid`, on a host read, and on any cycle with `in_valid`. A clear wins over a tick in the same cycle.
- R8: While the queue is empty nothing is counted and `tmo_flag` is low.
- R9: Once set, `tmo_flag` stays high through further ticks and stop-bit strobes. It clears on the next host read or the next cycle with `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-deep queue, 0: single holding register |
| trig_sel | input | 2 | Trigger level select (1, 4, 8, 14) |
| wlen_sel | input | 2 | Word length select (5 to 8 bits) |
| in_valid | input | 1 | Received character present |
| in_data | input | 8 | Received character |
| in_ready | output | 1 | Room for a character |
| stop_mid | input | 1 | Strobe at the centre of a received stop bit |
| bit_tick | input | 1 | One pulse per bit time |
| out_valid | output | 1 | Data ready: queue holds a character |
| out_data | output | 8 | Oldest stored character |
| out_ready | input | 1 | Host read of the holding register |
| status_rd | input | 1 | Host status read, clears overrun |
| trig_hit | output | 1 | Fill level at or above trigger |
| tmo_flag | output | 1 | Character timeout pending |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
The bench sweeps every trigger select across all fill levels from 1 to 16. A comparator off by one would flip `trig_hit` one character early or late. A design that stopped accepting at the trigger would raise `overrun` too soon. For every word length it sends exactly one tick fewer than the limit and then the final tick, which exposes a timer that fires at the wrong count. It applies a stop strobe in the same cycle as a tick, so a timer that lets the tick win over the clear would fire one tick early. It also sends ticks into an empty queue, which a timer that ignores occupancy would turn into a false timeout. It checks that a set flag survives further ticks and drops on a read, and it checks the single-register mode and the flush on an enable change.

// File: rtl/rx_char_queue_pkg.sv
package rx_char_queue_pkg;

  // Fill level that raises the trigger flag for each select code.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 1;
      2'd1:    trig_level = 4;
      2'd2:    trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction

  // Idle length in bit ticks: four per data bit plus twelve.
  function automatic int unsigned tmo_limit(input logic [1:0] wsel);
    tmo_limit = 4 * (32'(wsel) + 5) + 12;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    next_ptr = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign count     = count_q;

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));
  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> (count_q == CW'($past(count_q) + 1)));
  a_r4_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(1) && pop && !push && !flush) |=> (count_q == '0));

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_clr,
  input  logic          flag_clr,
  input  logic          nonempty,
  input  logic [TW-1:0] limit,
  output logic          flag
);

  logic [TW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!nonempty) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (flag_clr) flag_q <= 1'b0;
      if (cnt_clr) begin
        cnt_q <= '0;
      end else if (tick && !flag_q) begin
        if (cnt_q == limit - 1'b1) begin
          cnt_q  <= '0;
          flag_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign flag = flag_q;

  a_r8_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !nonempty |=> (cnt_q == '0 && !flag_q));
  a_r7_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && nonempty) |=> (cnt_q == '0));
  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr && nonempty) |=> flag_q);

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int TW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [1:0]    wlen_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          stop_mid,
  input  logic          bit_tick,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          status_rd,
  output logic          trig_hit,
  output logic          tmo_flag,
  output logic          overrun
);
  import rx_char_queue_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic          en_q, flush, push, pop, drop, ovr_q;
  logic [CW-1:0] count, cap;
  int unsigned   level;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush     = fifo_en ^ en_q;
  assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
  assign in_ready  = (count < cap) && !flush;
  assign push      = in_valid && in_ready;
  assign drop      = in_valid && !in_ready;
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready && !flush;

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (in_data),
    .pop       (pop),
    .flush     (flush),
    .head_data (out_data),
    .count     (count)
  );

  assign level    = fifo_en ? trig_level(trig_sel) : 32'd1;
  assign trig_hit = (32'(count) >= level);

  always_ff @(posedge clk) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (drop)      ovr_q <= 1'b1;
    else if (status_rd) ovr_q <= 1'b0;
  end
  assign overrun = ovr_q;

  rxq_idle_timer #(.TW(TW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .cnt_clr  (stop_mid | out_ready | in_valid | flush),
    .flag_clr (pop | in_valid | flush),
    .nonempty (out_valid),
    .limit    (TW'(tmo_limit(wlen_sel))),
    .flag     (tmo_flag)
  );

  a_r3_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  a_r3_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !drop) |=> !overrun);
  a_r8_no_timeout_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !tmo_flag);
  a_r5_trigger_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> out_valid);

endmodule

// File: tb/rx_char_queue_tb_top.sv
`timescale 1ns/1ps
module rx_char_queue_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic [1:0] trig_sel = 2'd0, wlen_sel = 2'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, trig_hit, tmo_flag, overrun;
  logic [7:0] out_data;
  logic       stop_mid = 1'b0, bit_tick = 1'b0, out_ready = 1'b0, status_rd = 1'b0;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  rx_char_queue dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .wlen_sel(wlen_sel), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .stop_mid(stop_mid), .bit_tick(bit_tick),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .status_rd(status_rd), .trig_hit(trig_hit), .tmo_flag(tmo_flag),
    .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input int exp);
    chk(tag, int'(out_data), exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  function automatic int lvl_of(input int s);
    case (s)
      0: lvl_of = 1;
      1: lvl_of = 4;
      2: lvl_of = 8;
      default: lvl_of = 14;
    endcase
  endfunction

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // Reset state
    chk("R4 reset out_valid", out_valid, 0);
    chk("R2 reset in_ready", in_ready, 1);
    chk("R5 reset trig_hit", trig_hit, 0);
    chk("R8 reset tmo_flag", tmo_flag, 0);
    chk("R3 reset overrun", overrun, 0);

    // R8: ticks into an empty queue
    ticks(60);
    chk("R8 empty ticks tmo_flag", tmo_flag, 0);

    // R5 / R1 / R3 / R4: trigger sweep over all selects and fill levels
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int n = 1; n <= 16; n++) begin
        push(8'(s * 16 + n));
        chk($sformatf("R5 sel%0d fill%0d trig_hit", s, n), trig_hit, (n >= lvl_of(s)) ? 1 : 0);
        chk($sformatf("R2 sel%0d fill%0d in_ready", s, n), in_ready, (n < 16) ? 1 : 0);
      end
      chk("R3 no overrun at full", overrun, 0);
      push(8'hEE);
      chk("R3 overrun after drop", overrun, 1);
      status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
      chk("R3 overrun cleared", overrun, 0);
      for (int n = 16; n >= 1; n--) begin
        chk($sformatf("R5 sel%0d drain%0d trig_hit", s, n), trig_hit, (n >= lvl_of(s)) ? 1 : 0);
        pop_chk($sformatf("R1 sel%0d order", s), s * 16 + (17 - n));
      end
      chk("R4 out_valid after last read", out_valid, 0);
    end

    // R6 / R7 / R9: timeout sweep over word lengths
    for (int w = 0; w < 4; w++) begin
      int lim;
      wlen_sel = 2'(w);
      lim = 4 * (w + 5) + 12;
      push(8'h11);
      ticks(lim - 1);
      chk($sformatf("R6 w%0d one short", w), tmo_flag, 0);
      ticks(1);
      chk($sformatf("R6 w%0d at limit", w), tmo_flag, 1);
      ticks(5);
      stop_mid = 1'b1; @(negedge clk); stop_mid = 1'b0;
      chk("R9 flag holds through ticks and stop", tmo_flag, 1);
      push(8'h22);
      chk("R9 new char clears flag", tmo_flag, 0);
      ticks(lim - 3);
      stop_mid = 1'b1; bit_tick = 1'b1; @(negedge clk);
      stop_mid = 1'b0; bit_tick = 1'b0;
      ticks(lim - 1);
      chk("R7 stop clear beats tick", tmo_flag, 0);
      ticks(1);
      chk("R7 full count after stop", tmo_flag, 1);
      pop_chk("R1 timeout first char", 8'h11);
      chk("R9 read clears flag", tmo_flag, 0);
      ticks(lim - 1);
      chk("R7 restart after read", tmo_flag, 0);
      ticks(1);
      chk("R7 fires after read restart", tmo_flag, 1);
      pop_chk("R1 timeout second char", 8'h22);
      chk("R8 flag low once empty", tmo_flag, 0);
      ticks(lim + 2);
      chk("R8 no count while empty", tmo_flag, 0);
    end

    // R2: single holding register mode, then flush on enable change
    fifo_en = 1'b0;
    idle(2);
    push(8'hA5);
    chk("R5 disabled trig at one", trig_hit, 1);
    chk("R2 disabled full", in_ready, 0);
    push(8'h5A);
    chk("R3 disabled overrun", overrun, 1);
    chk("R2 disabled keeps first", out_data, 8'hA5);
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    pop_chk("R1 disabled read", 8'hA5);
    chk("R4 disabled empty", out_valid, 0);
    push(8'h3C);
    chk("R4 disabled holds one", out_valid, 1);
    fifo_en = 1'b1;
    idle(2);
    chk("R2 enable change flushes", out_valid, 0);
    chk("R2 ready after flush", in_ready, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule